// File: doc/BRIEF.md
# Audio Serial Transmit Channel (Master)

This block turns audio samples into a serial stream with a word-select line, acting as the timing master of the link. A bus writes 32-bit words into an eight-entry queue. On every pulse of the bit-clock enable input, the channel moves one bit slot forward. At each left-phase start it pulls a word from the queue and sends the selected sample most significant bit first.

A set of static control inputs sets the serial format:
- sample width: 8, 16 or 32 bits;
- mono or stereo;
- the length of each word-select phase, which does not have to match the sample width;
- three run controls: halt, flush and silence.

The queue fill level is reported as a count. A refill request is raised while that count is at or below a programmable threshold. If the queue is empty when a word is needed, zeros are sent and a sticky underrun flag is set.

Top module: `i2s_tx_serializer`

## Requirements
- R1: `cfg_width` selects the sample width: 2'b00 is 8-bit, 2'b01 is 16-bit and 2'b11 is 32-bit. The code 2'b10 leaves the width that was last in force. The width after `rst_n` is 32-bit.
- R2: The queue holds 8 words and `fifo_level` reports its fill. A write that arrives while it holds 8 words is dropped.
- R3: `req_flag` is 1 exactly when `fifo_level` <= `req_level`.
- R4: `ws_out` is 0 in the left phase and 1 in the right phase. Each phase lasts `cfg_half`+1 bit-clock ticks.
  - The MSB of a phase's sample appears on `sd_out` one tick after the `ws_out` edge. Each following bit comes one tick later.
  - Slots beyond the sample width carry 0. Bits that do not fit in the phase are not sent.
- R5: In 8-bit or 16-bit stereo, one word carries both channels. The left sample is bits [W-1:0] and the right sample is bits [2W-1:W].
- R6: In 32-bit stereo, the left phase pops one word and the right phase pops the next.
- R7: In mono, one word is popped per frame. Its low W bits are sent in both phases.
- R8: While `cfg_stop` is 1, ticks are ignored and `ws_out`/`sd_out` hold. Clearing it resumes from the same slot.
- R9: While `cfg_reset` is 1, the block returns to idle:
  - the queue is emptied and writes are dropped;
  - `ws_out` is 1, `sd_out` is 0 and `underrun` is cleared;
  - the first tick after release starts a left phase.
- R10: While `cfg_mute` is 1, `sd_out` is 0. Word-select timing and queue pops continue unchanged.
- R11: A pop needed while the queue is empty sends a zero sample and sets `underrun`. The flag stays set until `cfg_reset` or `rst_n`.
- R12: A write and a pop in the same cycle are both honoured, and `fifo_level` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_en | input | 1 | One-cycle pulse per serial bit slot |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Word to queue |
| cfg_width | input | 2 | Sample width code |
| cfg_mono | input | 1 | 1 = mono, 0 = stereo |
| cfg_stop | input | 1 | Halt transmission |
| cfg_reset | input | 1 | Flush and return to idle |
| cfg_mute | input | 1 | Force serial data to zero |
| cfg_half | input | 9 | Word-select phase length minus one, in ticks |
| req_level | input | 4 | Request threshold |
| sd_out | output | 1 | Serial data |
| ws_out | output | 1 | Word select |
| fifo_level | output | 4 | Queue fill count |
| req_flag | output | 1 | Refill request |
| underrun | output | 1 | Sticky empty-queue flag |

## Verification
A bus write can land in the same cycle as a left-phase start, which pops the head word. The bench provokes this by raising `wr_en` together with the `bclk_en` pulse of every left-phase start over three frames. It then judges the outcome in two ways. The fill count must equal the count held before the frames. The serial stream must carry the written words in order, following the preloaded ones.

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
  parameter int DEPTH = 8,
  parameter int HW    = 9,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_en,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_mono,
  input  logic          cfg_stop,
  input  logic          cfg_reset,
  input  logic          cfg_mute,
  input  logic [HW-1:0] cfg_half,
  input  logic [LW-1:0] req_level,
  output logic          sd_out,
  output logic          ws_out,
  output logic [LW-1:0] fifo_level,
  output logic          req_flag,
  output logic          underrun
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] level;
  logic [1:0]    width_q;
  logic [HW-1:0] cnt;
  logic          ws_q, sd_q, urun_q;
  logic [31:0]   shreg, hold;

  logic tick, edge_t, to_left, to_right;
  logic w8, w32, need_pop, empty, pop, push;
  logic [31:0] fetched, right_pk;

  function automatic logic [31:0] align(input logic [31:0] v, input logic [1:0] wc);
    case (wc)
      2'b00:   align = {v[7:0], 24'b0};
      2'b01:   align = {v[15:0], 16'b0};
      default: align = v;
    endcase
  endfunction

  assign tick     = bclk_en & ~cfg_stop & ~cfg_reset;
  assign edge_t   = tick & (cnt >= cfg_half);
  assign to_left  = edge_t & ws_q;
  assign to_right = edge_t & ~ws_q;
  assign w8       = (width_q == 2'b00);
  assign w32      = (width_q == 2'b11);
  assign empty    = (level == '0);
  assign need_pop = to_left | (to_right & w32 & ~cfg_mono);
  assign pop      = need_pop & ~empty;
  assign push     = wr_en & ~cfg_reset & (level != LW'(DEPTH));
  assign fetched  = empty ? 32'b0 : mem[rp];
  assign right_pk = w8 ? {24'b0, fetched[15:8]} : {16'b0, fetched[31:16]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    width_q <= 2'b11;
    else if (cfg_width != 2'b10)   width_q <= cfg_width;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (cfg_reset) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push & ~pop)      level <= level + 1'b1;
      else if (pop & ~push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '1; ws_q <= 1'b1; sd_q <= 1'b0;
      shreg <= '0; hold <= '0; urun_q <= 1'b0;
    end else if (cfg_reset) begin
      cnt <= '1; ws_q <= 1'b1; sd_q <= 1'b0;
      shreg <= '0; hold <= '0; urun_q <= 1'b0;
    end else if (tick) begin
      sd_q <= cfg_mute ? 1'b0 : shreg[31];
      if (need_pop & empty) urun_q <= 1'b1;
      if (edge_t) begin
        cnt  <= '0;
        ws_q <= ~ws_q;
      end else begin
        cnt  <= cnt + 1'b1;
      end
      if (to_left) begin
        shreg <= align(fetched, width_q);
        hold  <= cfg_mono ? align(fetched, width_q) : align(right_pk, width_q);
      end else if (to_right) begin
        shreg <= (w32 & ~cfg_mono) ? fetched : hold;
      end else begin
        shreg <= {shreg[30:0], 1'b0};
      end
    end
  end

  assign sd_out     = sd_q;
  assign ws_out     = ws_q;
  assign fifo_level = level;
  assign req_flag   = (level <= req_level);
  assign underrun   = urun_q;
endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bclk_en,
  input logic          cfg_stop,
  input logic          cfg_reset,
  input logic          cfg_mute,
  input logic          sd_out,
  input logic          ws_out,
  input logic [LW-1:0] fifo_level,
  input logic          underrun
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH)); // R2

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_reset |=> (fifo_level == $past(fifo_level) || fifo_level == $past(fifo_level) + 1'b1
                    || fifo_level + 1'b1 == $past(fifo_level))); // R12

  AST_WS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!bclk_en && !cfg_reset) |=> $stable(ws_out)); // R4

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stop && !cfg_reset) |=> ($stable(ws_out) && $stable(sd_out))); // R8

  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> (fifo_level == '0 && ws_out && !sd_out && !underrun)); // R9

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mute && bclk_en && !cfg_stop) |=> !sd_out); // R10

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !cfg_reset) |=> underrun); // R11
endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .cfg_stop(cfg_stop),
  .cfg_reset(cfg_reset), .cfg_mute(cfg_mute), .sd_out(sd_out), .ws_out(ws_out),
  .fifo_level(fifo_level), .underrun(underrun)
);

// File: tb/i2s_tx_serializer_bench.sv
module i2s_tx_serializer_bench;
  logic clk = 0, rst_n = 0;
  logic bclk_en = 0, wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [1:0] cfg_width = 2'b01;
  logic cfg_mono = 0, cfg_stop = 1, cfg_reset = 0, cfg_mute = 0;
  logic [8:0] cfg_half = 9'd15;
  logic [3:0] req_level = '0;
  logic sd_out, ws_out, req_flag, underrun;
  logic [3:0] fifo_level;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R4";
  logic [1:0]  exp_q[$];
  logic [31:0] src_q[$];
  bit prev_bit = 0;

  always #5 clk = ~clk;

  i2s_tx_serializer u_i2s_tx_serializer (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_width(cfg_width), .cfg_mono(cfg_mono), .cfg_stop(cfg_stop), .cfg_reset(cfg_reset),
    .cfg_mute(cfg_mute), .cfg_half(cfg_half), .req_level(req_level),
    .sd_out(sd_out), .ws_out(ws_out), .fifo_level(fifo_level), .req_flag(req_flag),
    .underrun(underrun));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expected {ws,sd} per running tick
  always begin
    @(posedge clk);
    if (bclk_en && !cfg_stop && !cfg_reset && exp_q.size() > 0) begin
      logic [1:0] e;
      @(negedge clk);
      e = exp_q.pop_front();
      chk(cur_req, {30'b0, ws_out, sd_out}, {30'b0, e});
    end
  end

  function automatic logic [31:0] src_pop();
    if (src_q.size() == 0) return 32'b0;
    return src_q.pop_front();
  endfunction

  function automatic logic [31:0] al(logic [31:0] v, int w);
    return (w == 32) ? v : (v << (32 - w));
  endfunction

  task automatic push_phase(bit ws, logic [31:0] x, int half, bit mute);
    exp_q.push_back({ws, mute ? 1'b0 : prev_bit});
    for (int k = 1; k <= half; k++)
      exp_q.push_back({ws, (mute || k - 1 > 31) ? 1'b0 : x[31-(k-1)]});
    prev_bit = (half <= 31) ? x[31-half] : 1'b0;
  endtask

  task automatic gen_expect(int w, bit mono, int half, int frames, bit mute);
    for (int f = 0; f < frames; f++) begin
      logic [31:0] wd, l, r, m;
      m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      wd = src_pop();
      l  = wd & m;
      if (mono)         r = l;
      else if (w == 32) r = src_pop();
      else              r = (wd >> w) & m;
      push_phase(1'b0, al(l, w), half, mute);
      push_phase(1'b1, al(r, w), half, mute);
    end
  endtask

  task automatic write_word(logic [31:0] d, bit mirror);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (mirror) src_q.push_back(d);
  endtask

  task automatic flush();
    @(negedge clk); cfg_reset = 1;
    @(negedge clk); cfg_reset = 0;
    src_q.delete(); exp_q.delete(); prev_bit = 0;
  endtask

  task automatic tick(bit push, logic [31:0] d);
    @(negedge clk); bclk_en = 1; wr_en = push; wr_data = d;
    @(negedge clk); bclk_en = 0; wr_en = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(int n, int push_every, logic [31:0] pbase, int stop_at);
    @(negedge clk); cfg_stop = 0;
    for (int i = 0; i < n; i++) begin
      if (i == stop_at) begin
        logic ws0, sd0;
        @(negedge clk); cfg_stop = 1;
        @(negedge clk); ws0 = ws_out; sd0 = sd_out;
        for (int j = 0; j < 5; j++) tick(0, 0);
        chk("R8", {30'b0, ws_out, sd_out}, {30'b0, ws0, sd0});
        cfg_stop = 0;
      end
      tick(push_every > 0 && i % push_every == 0, pbase + i);
    end
    cfg_stop = 1;
    chk(cur_req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 idle state after reset
    chk("R9", fifo_level, 0); chk("R9", ws_out, 1); chk("R9", sd_out, 0);
    chk("R9", underrun, 0);   chk("R3", req_flag, 1);

    // R3 threshold, R2 capacity
    req_level = 4'd3;
    for (int i = 0; i < 10; i++) begin
      write_word(32'hA5C3_0000 + i * 32'h0101_0F37, i < 8);
      if (i < 5) chk("R3", req_flag, (i + 1) <= 3);
    end
    chk("R2", fifo_level, 8);

    // R5 8-bit stereo packing, R11 underrun in ninth frame
    cur_req = "R5"; cfg_width = 2'b00; cfg_mono = 0; cfg_half = 9'd7;
    @(negedge clk);
    gen_expect(8, 0, 7, 9, 0);
    run(144, 0, 0, -1);
    chk("R11", underrun, 1);
    chk("R2", fifo_level, 0);
    @(negedge clk); chk("R11", underrun, 1);

    flush();
    chk("R9", fifo_level, 0); chk("R9", underrun, 0); chk("R9", ws_out, 1);

    // R1 reserved code keeps 16-bit, R7 mono, long phase
    cur_req = "R7"; cfg_width = 2'b01; @(negedge clk); cfg_width = 2'b10;
    cfg_mono = 1; cfg_half = 9'd17;
    write_word(32'h1234_BEEF, 1); write_word(32'hFFFF_8001, 1);
    gen_expect(16, 1, 17, 2, 0);
    cur_req = "R1";
    run(72, 0, 0, -1);
    chk("R7", underrun, 0);
    chk("R7", fifo_level, 0);

    // R6 32-bit stereo with a halt in the middle
    flush();
    cur_req = "R6"; cfg_width = 2'b11; cfg_mono = 0; cfg_half = 9'd31;
    write_word(32'h8000_0001, 1); write_word(32'h0F0F_A5A5, 1);
    write_word(32'hDEAD_BEEF, 1); write_word(32'h7654_3210, 1);
    gen_expect(32, 0, 31, 2, 0);
    run(128, 0, 0, 40);
    chk("R6", fifo_level, 0); chk("R6", underrun, 0);

    // R4 phase shorter than sample
    flush();
    cur_req = "R4"; cfg_width = 2'b01; cfg_half = 9'd11;
    write_word(32'hC3A5_9F01, 1); write_word(32'h5A5A_F00F, 1);
    gen_expect(16, 0, 11, 2, 0);
    run(48, 0, 0, -1);

    // R10 mute keeps timing and consumes words
    flush();
    cur_req = "R10"; cfg_half = 9'd15; cfg_mute = 1;
    write_word(32'hFFFF_FFFF, 1); write_word(32'hFFFF_FFFF, 1);
    gen_expect(16, 0, 15, 2, 1);
    run(64, 0, 0, -1);
    chk("R10", fifo_level, 0); chk("R10", underrun, 0);
    cfg_mute = 0;

    // R12 write coincides with left-phase pop
    flush();
    cur_req = "R12";
    write_word(32'h1111_AAAA, 1); write_word(32'h2222_BBBB, 1);
    for (int i = 0; i < 3; i++) src_q.push_back(32'h0BAD_0000 + i * 32);
    gen_expect(16, 0, 15, 3, 0);
    run(96, 32, 32'h0BAD_0000, -1);
    chk("R12", fifo_level, 2);
    chk("R12", underrun, 0);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule